// File: doc/BRIEF.md
# Jump Instruction Length Decoder

This block sits behind an instruction byte stream in 32-bit mode. It takes one byte per cycle over a valid/ready handshake and finds the unconditional jump forms: the one-byte relative jump, the four-byte relative jump, and the indirect jump through a register or a memory operand. It walks any segment override prefixes, the ModRM byte, an optional SIB byte and the displacement bytes. It then emits a single descriptor per instruction over a second valid/ready handshake.

Each descriptor gives the jump kind, the total byte count (prefixes included), the last segment override seen, and the displacement or relative offset sign-extended to 32 bits. It also gives the raw base, index and scale fields, plus flags that say when no base register or no index register takes part. A later stage uses these to form the address; this block does no address arithmetic. Any byte that cannot start a supported jump produces a descriptor of kind "unsupported", and decoding carries on with the byte that follows.

Kind codes: 0 short relative, 1 near relative, 2 indirect through a register, 3 indirect through memory, 4 unsupported. Segment codes: 0 none, 1 for 0x26, 2 for 0x2E, 3 for 0x36, 4 for 0x3E, 5 for 0x64, 6 for 0x65.

Top module: `jmpdec_top`

## Requirements
- R1: Opcode 0xEB followed by one byte gives kind 0. The byte is sign-extended to 32 bits on out_disp, and the length is the prefix count plus 2.
- R2: Opcode 0xE9 followed by four bytes gives kind 1. The bytes are taken least significant first, and the length is the prefix count plus 5.
- R3: Opcode 0xFF with ModRM reg field (bits 5-3) equal to 4 and mod (bits 7-6) equal to 11 gives kind 2. out_base holds rm (bits 2-0), out_no_index is 1, out_no_base is 0, and the length is the prefix count plus 2.
- R4: For the memory form without a SIB byte (rm not 100, and not the mod=00/rm=101 case), the kind is 3 and out_base holds rm. mod 00 adds no displacement, mod 01 adds a sign-extended byte and mod 10 adds four bytes least significant first. out_no_index is 1.
- R5: mod=00 with rm=101 sets out_no_base and takes a 32-bit displacement after the ModRM byte (length 6 plus prefixes).
- R6: rm=100 with mod other than 11 reads a SIB byte. out_scale is SIB bits 7-6 (factor 1, 2, 4 or 8), out_index is bits 5-3 and out_base is bits 2-0. The displacement size then follows mod as in R4.
- R7: A SIB index code of 100 sets out_no_index, whatever the scale is.
- R8: A SIB base code of 101 under mod=00 sets out_no_base, and a 32-bit displacement follows the SIB byte.
- R9: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 are prefixes. The last one seen is reported on out_seg, and every prefix byte counts in the length.
- R10: Any other opcode, or 0xFF with a reg field other than 4, gives kind 4. The length is the number of bytes dropped (prefixes, the opcode, and the ModRM byte if one was read). out_disp is 0, both flags are set, and the next byte starts a new instruction.
- R11: A prefix arriving when MAX_PFX prefixes are already held ends the instruction as kind 4, and the length includes that prefix. The segment reported is the one held before it.
- R12: While out_valid is high and out_ready is low, the descriptor holds steady and in_ready is low.
- R13: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte taken this cycle when in_valid is also high |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_kind | output | 3 | Jump kind code |
| out_len | output | LEN_W | Total byte count |
| out_seg | output | 3 | Segment override code |
| out_disp | output | DISP_W | Sign-extended displacement or offset |
| out_base | output | 3 | Base register code |
| out_index | output | 3 | Index register code |
| out_scale | output | 2 | Scale code |
| out_no_base | output | 1 | No base register takes part |
| out_no_index | output | 1 | No index register takes part |

## Verification
The bench targets the two displacement-only escapes: mod=00 with rm=101, and a SIB base of 101 under mod=00. A design that missed either would emit the descriptor early and misread the displacement bytes as new opcodes. It also targets a SIB byte under mod=01, where missing the SIB step shifts every later byte by one. It covers negative short offsets, which go wrong without sign extension, and four-byte offsets with the top bit set. It checks several stacked prefixes, where "last wins" and the length count are easy to get wrong, and the prefix overflow. It also covers a group opcode with the wrong reg field, after which the stream must resynchronise. A pseudo-random stream with random backpressure checks that no descriptor is dropped, repeated or changed while stalled.

// File: rtl/jmpdec_pkg.sv
`timescale 1ns/1ps
package jmpdec_pkg;

   typedef enum logic [2:0] {
      K_REL8    = 3'd0,
      K_REL32   = 3'd1,
      K_IND_REG = 3'd2,
      K_IND_MEM = 3'd3,
      K_UNSUP   = 3'd4
   } jkind_t;

   typedef enum logic [1:0] {
      ST_OPC   = 2'd0,
      ST_MODRM = 2'd1,
      ST_SIB   = 2'd2,
      ST_DISP  = 2'd3
   } dstate_t;

   localparam logic [7:0] OPC_SHORT = 8'hEB;
   localparam logic [7:0] OPC_NEAR  = 8'hE9;
   localparam logic [7:0] OPC_GROUP = 8'hFF;
   localparam logic [2:0] GROUP_JMP = 3'd4;
   localparam logic [2:0] CODE_ESC  = 3'b100;
   localparam logic [2:0] CODE_DOFS = 3'b101;

   // Map a byte to its segment override code; zero means "not a prefix".
   function automatic logic [2:0] seg_code(input logic [7:0] b);
      logic [2:0] c;
      unique case (b)
         8'h26:   c = 3'd1;
         8'h2E:   c = 3'd2;
         8'h36:   c = 3'd3;
         8'h3E:   c = 3'd4;
         8'h64:   c = 3'd5;
         8'h65:   c = 3'd6;
         default: c = 3'd0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/jmpdec_modrm_cls.sv
`timescale 1ns/1ps
module jmpdec_modrm_cls
   import jmpdec_pkg::*;
(
   input  logic [7:0] modrm,
   output logic       reg_is_jmp,
   output logic       is_reg_form,
   output logic       wants_sib,
   output logic       disp_only,
   output logic [2:0] disp_len
);
   logic [1:0] md;
   logic [2:0] rm;

   assign md          = modrm[7:6];
   assign rm          = modrm[2:0];
   assign reg_is_jmp  = (modrm[5:3] == GROUP_JMP);
   assign is_reg_form = (md == 2'b11);
   assign wants_sib   = !is_reg_form && (rm == CODE_ESC);
   assign disp_only   = (md == 2'b00) && (rm == CODE_DOFS);

   always_comb begin
      unique case (md)
         2'b00:   disp_len = disp_only ? 3'd4 : 3'd0;
         2'b01:   disp_len = 3'd1;
         2'b10:   disp_len = 3'd4;
         default: disp_len = 3'd0;
      endcase
   end
endmodule

// File: rtl/jmpdec_sib_cls.sv
`timescale 1ns/1ps
module jmpdec_sib_cls
   import jmpdec_pkg::*;
(
   input  logic [7:0] sib,
   input  logic [1:0] md,
   output logic [1:0] scale,
   output logic [2:0] idx,
   output logic [2:0] base,
   output logic       no_index,
   output logic       no_base,
   output logic [2:0] disp_len
);
   assign scale    = sib[7:6];
   assign idx      = sib[5:3];
   assign base     = sib[2:0];
   assign no_index = (idx == CODE_ESC);
   assign no_base  = (md == 2'b00) && (base == CODE_DOFS);

   always_comb begin
      unique case (md)
         2'b00:   disp_len = no_base ? 3'd4 : 3'd0;
         2'b01:   disp_len = 3'd1;
         2'b10:   disp_len = 3'd4;
         default: disp_len = 3'd0;
      endcase
   end
endmodule

// File: rtl/jmpdec_disp_acc.sv
`timescale 1ns/1ps
module jmpdec_disp_acc #(
   parameter int DISP_W = 32,
   localparam int LANES  = DISP_W / 8,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [LANE_W-1:0] lane,
   input  logic [7:0]        din,
   input  logic              wide,
   output logic [DISP_W-1:0] ext
);
   logic [DISP_W-1:0] merged;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [7:0] q;
         logic       hit;
         assign hit = wr && (lane == LANE_W'(g));
         always_ff @(posedge clk) begin
            if (!rst_n || clr) q <= '0;
            else if (hit)      q <= din;
         end
         assign merged[g*8 +: 8] = hit ? din : q;
      end
   endgenerate

   assign ext = wide ? merged : {{(DISP_W-8){merged[7]}}, merged[7:0]};
endmodule

// File: rtl/jmpdec_top.sv
`timescale 1ns/1ps
module jmpdec_top
   import jmpdec_pkg::*;
#(
   parameter int MAX_PFX = 4,
   parameter int LEN_W   = 5,
   parameter int DISP_W  = 32,
   localparam int PFX_W  = $clog2(MAX_PFX + 1),
   localparam int LANES  = DISP_W / 8,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [2:0]        out_kind,
   output logic [LEN_W-1:0]  out_len,
   output logic [2:0]        out_seg,
   output logic [DISP_W-1:0] out_disp,
   output logic [2:0]        out_base,
   output logic [2:0]        out_index,
   output logic [1:0]        out_scale,
   output logic              out_no_base,
   output logic              out_no_index
);

   generate
      if (MAX_PFX < 1)
         $error("MAX_PFX must be at least 1");
      if ((MAX_PFX + 7) >= (1 << LEN_W))
         $error("LEN_W too narrow for the longest instruction");
      if ((DISP_W % 8) != 0 || DISP_W < 32)
         $error("DISP_W must be a multiple of 8, at least 32");
   endgenerate

   // ---------------- state ----------------
   dstate_t           st_q, st_d;
   logic [PFX_W-1:0]  pfx_q, pfx_d;
   logic [2:0]        seg_q, seg_d;
   logic [LEN_W-1:0]  len_q, len_d;
   jkind_t            kind_q, kind_d;
   logic [1:0]        mod_q, mod_d;
   logic [2:0]        base_q, base_d, idx_q, idx_d;
   logic [1:0]        scale_q, scale_d;
   logic              nb_q, nb_d, ni_q, ni_d;
   logic [2:0]        left_q, left_d;
   logic [LANE_W-1:0] lane_q, lane_d;
   logic              wide_q, wide_d;

   // ---------------- output register ----------------
   logic              o_valid;
   jkind_t            o_kind;
   logic [LEN_W-1:0]  o_len;
   logic [2:0]        o_seg;
   logic [DISP_W-1:0] o_disp;
   logic [2:0]        o_base, o_idx;
   logic [1:0]        o_scale;
   logic              o_nb, o_ni;

   // ---------------- classifiers ----------------
   logic       m_jmp, m_reg, m_sib, m_donly;
   logic [2:0] m_dlen;
   logic [1:0] s_scale;
   logic [2:0] s_idx, s_base, s_dlen;
   logic       s_ni, s_nb;

   jmpdec_modrm_cls u_modrm (
      .modrm       (in_byte),
      .reg_is_jmp  (m_jmp),
      .is_reg_form (m_reg),
      .wants_sib   (m_sib),
      .disp_only   (m_donly),
      .disp_len    (m_dlen)
   );

   jmpdec_sib_cls u_sib (
      .sib      (in_byte),
      .md       (mod_q),
      .scale    (s_scale),
      .idx      (s_idx),
      .base     (s_base),
      .no_index (s_ni),
      .no_base  (s_nb),
      .disp_len (s_dlen)
   );

   logic              fire, emit, acc_wr;
   logic [DISP_W-1:0] acc_ext;
   logic [2:0]        pcode;

   assign in_ready = !o_valid || out_ready;
   assign fire     = in_valid && in_ready;
   assign pcode    = seg_code(in_byte);

   jmpdec_disp_acc #(.DISP_W(DISP_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (emit),
      .wr    (acc_wr),
      .lane  (lane_q),
      .din   (in_byte),
      .wide  (wide_q),
      .ext   (acc_ext)
   );

   // descriptor fields presented at emit
   jkind_t            e_kind;
   logic [DISP_W-1:0] e_disp;
   logic [2:0]        e_base, e_idx;
   logic [1:0]        e_scale;
   logic              e_nb, e_ni;

   always_comb begin
      st_d    = st_q;    pfx_d   = pfx_q;   seg_d  = seg_q;
      len_d   = len_q;   kind_d  = kind_q;  mod_d  = mod_q;
      base_d  = base_q;  idx_d   = idx_q;   scale_d = scale_q;
      nb_d    = nb_q;    ni_d    = ni_q;    left_d = left_q;
      lane_d  = lane_q;  wide_d  = wide_q;
      emit    = 1'b0;    acc_wr  = 1'b0;
      e_kind  = K_UNSUP; e_disp  = '0;
      e_base  = 3'd0;    e_idx   = 3'd0;    e_scale = 2'd0;
      e_nb    = 1'b1;    e_ni    = 1'b1;

      if (fire) begin
         len_d = len_q + 1'b1;
         unique case (st_q)
            ST_OPC: begin
               if (pcode != 3'd0) begin
                  if (pfx_q == PFX_W'(MAX_PFX)) begin
                     emit = 1'b1;               // too many prefixes
                  end else begin
                     pfx_d = pfx_q + 1'b1;
                     seg_d = pcode;
                  end
               end else if (in_byte == OPC_SHORT || in_byte == OPC_NEAR) begin
                  kind_d  = (in_byte == OPC_SHORT) ? K_REL8 : K_REL32;
                  wide_d  = (in_byte == OPC_NEAR);
                  left_d  = (in_byte == OPC_NEAR) ? 3'd4 : 3'd1;
                  lane_d  = '0;
                  base_d  = 3'd0; idx_d = 3'd0; scale_d = 2'd0;
                  nb_d    = 1'b1; ni_d  = 1'b1;
                  st_d    = ST_DISP;
               end else if (in_byte == OPC_GROUP) begin
                  st_d = ST_MODRM;
               end else begin
                  emit = 1'b1;
               end
            end
            ST_MODRM: begin
               if (!m_jmp) begin
                  emit = 1'b1;
               end else if (m_reg) begin
                  emit   = 1'b1;
                  e_kind = K_IND_REG;
                  e_base = in_byte[2:0];
                  e_nb   = 1'b0;
               end else if (m_sib) begin
                  kind_d = K_IND_MEM;
                  mod_d  = in_byte[7:6];
                  st_d   = ST_SIB;
               end else if (m_dlen == 3'd0) begin
                  emit   = 1'b1;
                  e_kind = K_IND_MEM;
                  e_base = in_byte[2:0];
                  e_nb   = 1'b0;
               end else begin
                  kind_d  = K_IND_MEM;
                  base_d  = in_byte[2:0];
                  idx_d   = 3'd0; scale_d = 2'd0;
                  nb_d    = m_donly; ni_d = 1'b1;
                  left_d  = m_dlen;
                  wide_d  = (m_dlen == 3'd4);
                  lane_d  = '0;
                  st_d    = ST_DISP;
               end
            end
            ST_SIB: begin
               if (s_dlen == 3'd0) begin
                  emit    = 1'b1;
                  e_kind  = K_IND_MEM;
                  e_base  = s_base;
                  e_idx   = s_idx;
                  e_scale = s_scale;
                  e_nb    = 1'b0;
                  e_ni    = s_ni;
               end else begin
                  base_d  = s_base; idx_d = s_idx; scale_d = s_scale;
                  nb_d    = s_nb;   ni_d  = s_ni;
                  left_d  = s_dlen;
                  wide_d  = (s_dlen == 3'd4);
                  lane_d  = '0;
                  st_d    = ST_DISP;
               end
            end
            default: begin // ST_DISP
               acc_wr = 1'b1;
               lane_d = lane_q + 1'b1;
               left_d = left_q - 3'd1;
               if (left_q == 3'd1) begin
                  emit    = 1'b1;
                  e_kind  = kind_q;
                  e_disp  = acc_ext;
                  e_base  = base_q;
                  e_idx   = idx_q;
                  e_scale = scale_q;
                  e_nb    = nb_q;
                  e_ni    = ni_q;
               end
            end
         endcase

         if (emit) begin
            st_d  = ST_OPC;
            pfx_d = '0;
            seg_d = 3'd0;
            len_d = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_OPC;  pfx_q  <= '0;     seg_q   <= 3'd0;
         len_q  <= '0;      kind_q <= K_UNSUP; mod_q  <= 2'd0;
         base_q <= 3'd0;    idx_q  <= 3'd0;   scale_q <= 2'd0;
         nb_q   <= 1'b1;    ni_q   <= 1'b1;   left_q  <= 3'd0;
         lane_q <= '0;      wide_q <= 1'b0;
      end else begin
         st_q   <= st_d;    pfx_q  <= pfx_d;  seg_q   <= seg_d;
         len_q  <= len_d;   kind_q <= kind_d; mod_q   <= mod_d;
         base_q <= base_d;  idx_q  <= idx_d;  scale_q <= scale_d;
         nb_q   <= nb_d;    ni_q   <= ni_d;   left_q  <= left_d;
         lane_q <= lane_d;  wide_q <= wide_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_kind  <= K_UNSUP; o_len <= '0;   o_seg   <= 3'd0;
         o_disp  <= '0;      o_base <= 3'd0; o_idx  <= 3'd0;
         o_scale <= 2'd0;    o_nb  <= 1'b1;  o_ni    <= 1'b1;
      end else begin
         if (emit)           o_valid <= 1'b1;
         else if (out_ready) o_valid <= 1'b0;
         if (emit) begin
            o_kind  <= e_kind;
            o_len   <= len_q + 1'b1;
            o_seg   <= seg_q;
            o_disp  <= e_disp;
            o_base  <= e_base;
            o_idx   <= e_idx;
            o_scale <= e_scale;
            o_nb    <= e_nb;
            o_ni    <= e_ni;
         end
      end
   end

   assign out_valid    = o_valid;
   assign out_kind     = o_kind;
   assign out_len      = o_len;
   assign out_seg      = o_seg;
   assign out_disp     = o_disp;
   assign out_base     = o_base;
   assign out_index    = o_idx;
   assign out_scale    = o_scale;
   assign out_no_base  = o_nb;
   assign out_no_index = o_ni;

   // ---------------- assertions ----------------
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_len)
                                  && $stable(out_disp) && $stable(out_seg)); // R12
   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R12
   AST_SHORT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 3'd0 |->
         (out_disp[DISP_W-1:7] == '0 || out_disp[DISP_W-1:7] == '1) && out_len >= LEN_W'(2)); // R1
   AST_REG_FORM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 3'd2 |-> out_no_index && !out_no_base && out_len >= LEN_W'(2)); // R3
   AST_NOBASE_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 3'd3 && out_no_base |-> out_len >= LEN_W'(6)); // R5
   AST_UNSUP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 3'd4 |-> out_disp == '0 && out_no_base && out_no_index); // R10
   AST_PFX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_q <= PFX_W'(MAX_PFX)); // R11

endmodule

// File: tb/test_jmpdec_top.sv
`timescale 1ns/1ps
module test_jmpdec_top;
   localparam int MAX_PFX = 4;
   localparam int LEN_W   = 5;
   localparam int DISP_W  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_byte = 8'h00;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [2:0]  out_kind;
   logic [LEN_W-1:0]  out_len;
   logic [2:0]  out_seg;
   logic [DISP_W-1:0] out_disp;
   logic [2:0]  out_base, out_index;
   logic [1:0]  out_scale;
   logic        out_no_base, out_no_index;

   always #2 clk = ~clk; // 250 MHz

   jmpdec_top #(.MAX_PFX(MAX_PFX), .LEN_W(LEN_W), .DISP_W(DISP_W)) i_jmpdec_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_len(out_len),
      .out_seg(out_seg), .out_disp(out_disp), .out_base(out_base), .out_index(out_index),
      .out_scale(out_scale), .out_no_base(out_no_base), .out_no_index(out_no_index)
   );

   typedef struct packed {
      logic [2:0]  kind;
      logic [4:0]  len;
      logic [2:0]  seg;
      logic [31:0] disp;
      logic [2:0]  base;
      logic [2:0]  idx;
      logic [1:0]  scale;
      logic        nb;
      logic        ni;
   } desc_t;

   logic [7:0] stim[$];
   desc_t      expq[$];
   string      tagq[$];
   int n_checks = 0;
   int n_fail   = 0;
   int unsigned rng = 32'h1234_5678;

   function automatic int unsigned next_rng(int unsigned s);
      int unsigned x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic int segc(logic [7:0] b);
      case (b)
         8'h26: return 1;
         8'h2E: return 2;
         8'h36: return 3;
         8'h3E: return 4;
         8'h64: return 5;
         8'h65: return 6;
         default: return 0;
      endcase
   endfunction

   task automatic put(int n, logic [63:0] v);
      for (int i = n - 1; i >= 0; i--) stim.push_back(v[i*8 +: 8]);
   endtask

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Software decode of the whole byte stream, written from the requirements.
   task automatic model_all();
      int p, n, start, npfx, dn, md, rg, rm;
      bit done;
      logic [7:0] op, m, s;
      desc_t e;
      string tg;
      n = stim.size();
      p = 0;
      while (p < n) begin
         start = p; npfx = 0; done = 0; tg = "";
         e = '0; e.nb = 1'b1; e.ni = 1'b1; e.kind = 3'd4;
         while (!done && p < n && segc(stim[p]) != 0) begin
            if (npfx == MAX_PFX) begin
               p++; done = 1; tg = "R11";
            end else begin
               e.seg = 3'(segc(stim[p])); npfx++; p++;
            end
         end
         if (!done) begin
            if (p >= n) break;
            op = stim[p]; p++;
            if (op == 8'hEB) begin
               if (p >= n) break;
               e.kind = 3'd0; e.disp = {{24{stim[p][7]}}, stim[p]}; p++; tg = "R1";
            end else if (op == 8'hE9) begin
               if (p + 4 > n) break;
               e.kind = 3'd1; e.disp = {stim[p+3], stim[p+2], stim[p+1], stim[p]}; p += 4; tg = "R2";
            end else if (op == 8'hFF) begin
               if (p >= n) break;
               m = stim[p]; p++;
               md = int'(m[7:6]); rg = int'(m[5:3]); rm = int'(m[2:0]);
               if (rg != 4) begin
                  tg = "R10";
               end else if (md == 3) begin
                  e.kind = 3'd2; e.base = 3'(rm); e.nb = 1'b0; tg = "R3";
               end else begin
                  e.kind = 3'd3; dn = 0;
                  if (rm == 4) begin
                     if (p >= n) break;
                     s = stim[p]; p++;
                     e.scale = s[7:6]; e.idx = s[5:3]; e.base = s[2:0];
                     e.ni = (s[5:3] == 3'd4); e.nb = 1'b0;
                     if (md == 0 && s[2:0] == 3'd5) begin e.nb = 1'b1; dn = 4; tg = "R8"; end
                     else tg = e.ni ? "R7" : "R6";
                  end else begin
                     e.base = 3'(rm); e.nb = 1'b0;
                     if (md == 0 && rm == 5) begin e.nb = 1'b1; dn = 4; tg = "R5"; end
                     else tg = "R4";
                  end
                  if (md == 1) dn = 1;
                  if (md == 2) dn = 4;
                  if (p + dn > n) break;
                  if (dn == 1) e.disp = {{24{stim[p][7]}}, stim[p]};
                  if (dn == 4) e.disp = {stim[p+3], stim[p+2], stim[p+1], stim[p]};
                  p += dn;
               end
            end else begin
               tg = "R10";
            end
            if (npfx > 0 && e.kind != 3'd4) tg = "R9";
         end
         e.len = 5'(p - start);
         expq.push_back(e);
         tagq.push_back(tg);
      end
   endtask

   task automatic add_directed();
      put(2, 64'hEB05);                 // R1 positive
      put(2, 64'hEBF0);                 // R1 negative
      put(5, 64'hE978563412);           // R2
      put(5, 64'hE900000080);           // R2 top bit set
      put(2, 64'hFFE0);                 // R3
      put(2, 64'hFFE7);                 // R3
      put(2, 64'hFF20);                 // R4 mod 00
      put(3, 64'hFF65F8);               // R4 mod 01 negative
      put(6, 64'hFFA644332211);         // R4 mod 10
      put(6, 64'hFF25EFBEADDE);         // R5
      put(4, 64'hFF64107F);             // R6 SIB under mod 01
      put(4, 64'hFF642410);             // R7 no index
      put(7, 64'hFF248D00100000);       // R8
      put(7, 64'hFF24E578563412);       // R7 and R8
      put(7, 64'hFFA4C304030201);       // R6 mod 10
      put(7, 64'h64FF2501020304);       // R9
      put(5, 64'h262E3EFF20);           // R9 last wins
      put(3, 64'h36EB02);               // R9
      put(4, 64'h6564FFE1);             // R9
      put(1, 64'h90);                   // R10
      put(2, 64'hFF10);                 // R10 wrong reg field
      put(2, 64'h2EC3);                 // R10 with prefix
      put(5, 64'h2626262626);           // R11
      put(2, 64'hEB00);                 // resumes
   endtask

   initial begin
      int n_dir, n_total, sp, wd;
      bit prev_stall, bp, hung;
      desc_t saved, act;
      logic [7:0] pfx_tab [6] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};

      add_directed();
      n_dir = stim.size();
      add_directed();
      for (int r = 0; r < 80; r++) begin
         rng = next_rng(rng);
         case (rng % 6)
            0: begin stim.push_back(8'hEB); rng = next_rng(rng); stim.push_back(rng[7:0]); end
            1: begin stim.push_back(8'hE9);
                  for (int k = 0; k < 4; k++) begin rng = next_rng(rng); stim.push_back(rng[7:0]); end end
            2, 3: begin stim.push_back(8'hFF); rng = next_rng(rng);
                  stim.push_back((rng[7:0] & 8'hC7) | 8'h20);
                  for (int k = 0; k < 5; k++) begin rng = next_rng(rng); stim.push_back(rng[15:8]); end end
            4: begin rng = next_rng(rng); stim.push_back(pfx_tab[rng % 6]); end
            default: begin rng = next_rng(rng); stim.push_back(rng[23:16]); end
         endcase
      end
      for (int k = 0; k < 12; k++) stim.push_back(8'h90);
      n_total = stim.size();
      model_all();

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R13", "out_valid after reset", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R13", "in_ready after reset", 64'(in_ready), 64'd1);
      rst_n = 1'b1;

      sp = 0; wd = 0; prev_stall = 0; hung = 0; saved = '0;
      while (sp < n_total || expq.size() > 0) begin
         @(negedge clk);
         wd++;
         if (wd > 100000) begin hung = 1; break; end
         act = {out_kind, out_len, out_seg, out_disp, out_base, out_index, out_scale,
                out_no_base, out_no_index};
         if (prev_stall)
            chk(out_valid && act == saved, "R12", "descriptor held while stalled",
                64'(act), 64'(saved));
         bp = (sp >= n_dir);
         rng = next_rng(rng);
         out_ready = bp ? (rng[0] | rng[3]) : 1'b1;
         in_valid  = (sp < n_total) && (bp ? (rng[5] | rng[2]) : 1'b1);
         in_byte   = in_valid ? stim[sp] : 8'h00;
         #1;
         if (out_valid && !out_ready)
            chk(!in_ready, "R12", "in_ready while stalled", 64'(in_ready), 64'd0);
         if (in_valid && in_ready) sp++;
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R10", "unexpected descriptor", 64'(act), 64'd0);
            end else begin
               desc_t ex;
               string tg;
               ex = expq.pop_front();
               tg = tagq.pop_front();
               chk(act == ex, tg, "descriptor", 64'(act), 64'(ex));
            end
         end
         prev_stall = out_valid && !out_ready;
         saved = act;
      end

      if (hung) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog R12 actual=%0d expected=%0d", expq.size(), 0);
      end else begin
         @(negedge clk);
         in_valid = 1'b0; out_ready = 1'b1;
         repeat (10) @(negedge clk);
         chk(out_valid == 1'b0, "R10", "no extra descriptor", 64'(out_valid), 64'd0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule